// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Controller

This block steers a five-stage in-order load/store pipeline whose stages run fetch, decode, execute, memory access and writeback in that order. Each cycle it looks at the source register numbers of the instruction in decode. It also looks at the destination numbers and register-write bits of the two older instructions in execute and memory access, whether the memory-stage instruction touches memory, and whether a branch resolved in execute is taken. From these it drives the write enables and synchronous clears of the four pipeline registers and the program counter. It also decides which side owns the single shared memory port.

There is no forwarding path, so an instruction that needs a result still held in execute or memory access waits in decode while a bubble goes down the pipe. The register file writes early and reads late in a cycle, so a writer already in writeback never blocks anyone. When the memory-stage instruction is a load or a store, the port serves that instruction and fetch waits for the cycle. A taken branch flushes the two younger instructions and lets the program counter take the target. Two counters record stall cycles and flush cycles, so the cost in cycles per instruction can be measured.

Top module: `hzd_ctrl`

## Requirements
- R1: While rst_n is low, every pipeline-register clear (ifid_clr, idex_clr, exmem_clr, memwb_clr) is 1, pc_we is 1, and both counters are held at 0.
- R2: When a source that decode uses (id_src_a with id_src_a_used, or id_src_b with id_src_b_used) is nonzero and equals ex_wr_dst while ex_wr_en is 1, and no branch is taken, then pc_we=0, ifid_we=0 and idex_clr=1.
- R3: The same stall as R2 occurs when the match is against mem_wr_dst with mem_wr_en set.
- R4: No data stall occurs when the matching destination is register 0, when the producer's write bit is 0, or when the matching source is flagged as unused.
- R5: port_to_data equals mem_is_access (1 gives the port to the memory stage, 0 to fetch). With no taken branch and no data stall, a busy port gives pc_we=0 and ifid_clr=1, and ID/EX is not cleared.
- R6: When ex_taken is 1, ifid_clr=1, idex_clr=1 and pc_we=1, whatever data or port hazard is also present.
- R7: Out of reset the older stages always advance: exmem_we=1, memwb_we=1, exmem_clr=0, memwb_clr=0.
- R8: stall_cnt rises by exactly one after every cycle in which pc_we is 0 out of reset, and otherwise keeps its value.
- R9: flush_cnt rises by exactly one after every cycle with ex_taken=1 out of reset, and otherwise keeps its value.
- R10: When a data stall and a busy port occur together (no taken branch), IF/ID is held (ifid_we=0, ifid_clr=0), not cleared.
- R11: With no hazard at all, every write enable is 1 and every clear is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_src_a | input | 5 | First source register of the decode instruction |
| id_src_a_used | input | 1 | Decode instruction reads id_src_a |
| id_src_b | input | 5 | Second source register of the decode instruction |
| id_src_b_used | input | 1 | Decode instruction reads id_src_b |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_wr_dst | input | 5 | Destination of the execute-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_wr_dst | input | 5 | Destination of the memory-stage instruction |
| mem_is_access | input | 1 | Memory-stage instruction is a load or store |
| ex_taken | input | 1 | Branch in execute is taken |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | IF/ID write enable |
| ifid_clr | output | 1 | IF/ID clear to bubble |
| idex_we | output | 1 | ID/EX write enable |
| idex_clr | output | 1 | ID/EX clear to bubble |
| exmem_we | output | 1 | EX/MEM write enable |
| exmem_clr | output | 1 | EX/MEM clear to bubble |
| memwb_we | output | 1 | MEM/WB write enable |
| memwb_clr | output | 1 | MEM/WB clear to bubble |
| port_to_data | output | 1 | Memory port granted to the memory stage (else fetch) |
| stall_cnt | output | 16 | Count of stall cycles |
| flush_cnt | output | 16 | Count of taken-branch flush cycles |

## Verification
On every cycle the assertions check these relations: the reset bubbles, a taken branch overriding everything, a busy port blocking the program counter, a held IF/ID always coming with an ID/EX bubble, the older stages never stalling, and the single-step growth of both counters. Which producer, source and register number actually start a data stall can only be shown by the bench's scenarios. So can the register-0 and unused-source exemptions and the exact mix of enables under each combination of hazards. The bench drives those combinations and compares each against an expected control set.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   // Control pair for one pipeline register
   typedef struct packed {
      logic we;
      logic clr;
   } stage_ctl_t;

   localparam stage_ctl_t STAGE_RUN    = '{we: 1'b1, clr: 1'b0};
   localparam stage_ctl_t STAGE_HOLD   = '{we: 1'b0, clr: 1'b0};
   localparam stage_ctl_t STAGE_BUBBLE = '{we: 1'b1, clr: 1'b1};
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
   parameter int REG_AW = 5,
   parameter int NPROD  = 2
) (
   input  logic [REG_AW-1:0]       src,
   input  logic                    src_used,
   input  logic [NPROD-1:0]        prod_wr,
   input  logic [NPROD*REG_AW-1:0] prod_dst,
   output logic                    hit
);
   logic [NPROD-1:0] per_prod;

   for (genvar p = 0; p < NPROD; p++) begin : g_prod
      assign per_prod[p] = prod_wr[p] &&
                           (prod_dst[p*REG_AW +: REG_AW] == src);
   end

   // register 0 is hardwired and never a real dependence
   assign hit = src_used && (src != '0) && (|per_prod);
endmodule

// File: rtl/hzd_seq.sv
module hzd_seq
   import hzd_pkg::*;
(
   input  logic       rst_n,
   input  logic       raw,
   input  logic       port_busy,
   input  logic       taken,
   output logic       pc_we,
   output stage_ctl_t ifid,
   output stage_ctl_t idex,
   output stage_ctl_t exmem,
   output stage_ctl_t memwb,
   output logic       stall_evt,
   output logic       flush_evt
);
   always_comb begin
      pc_we = 1'b1;
      ifid  = STAGE_RUN;
      idex  = STAGE_RUN;
      exmem = STAGE_RUN;
      memwb = STAGE_RUN;
      if (!rst_n) begin
         ifid  = STAGE_BUBBLE;
         idex  = STAGE_BUBBLE;
         exmem = STAGE_BUBBLE;
         memwb = STAGE_BUBBLE;
      end else if (taken) begin
         ifid = STAGE_BUBBLE;
         idex = STAGE_BUBBLE;
      end else if (raw) begin
         pc_we = 1'b0;
         ifid  = STAGE_HOLD;
         idex  = STAGE_BUBBLE;
      end else if (port_busy) begin
         pc_we = 1'b0;
         ifid  = STAGE_BUBBLE;
      end
   end

   assign stall_evt = rst_n && !taken && (raw || port_busy);
   assign flush_evt = rst_n && taken;
endmodule

// File: rtl/hzd_evt_cnt.sv
module hzd_evt_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + 1'b1;
   end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
   import hzd_pkg::*;
#(
   parameter int REG_AW = 5,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] id_src_a,
   input  logic              id_src_a_used,
   input  logic [REG_AW-1:0] id_src_b,
   input  logic              id_src_b_used,
   input  logic              ex_wr_en,
   input  logic [REG_AW-1:0] ex_wr_dst,
   input  logic              mem_wr_en,
   input  logic [REG_AW-1:0] mem_wr_dst,
   input  logic              mem_is_access,
   input  logic              ex_taken,
   output logic              pc_we,
   output logic              ifid_we,
   output logic              ifid_clr,
   output logic              idex_we,
   output logic              idex_clr,
   output logic              exmem_we,
   output logic              exmem_clr,
   output logic              memwb_we,
   output logic              memwb_clr,
   output logic              port_to_data,
   output logic [CNT_W-1:0]  stall_cnt,
   output logic [CNT_W-1:0]  flush_cnt
);
   localparam int NSRC  = 2;
   localparam int NPROD = 2;

   if (REG_AW < 1 || CNT_W < 2) begin : g_bad_param
      $error("hzd_ctrl: REG_AW must be >= 1 and CNT_W >= 2");
   end

   logic [NSRC*REG_AW-1:0]  srcs;
   logic [NSRC-1:0]         src_used;
   logic [NSRC-1:0]         src_hit;
   logic [NPROD-1:0]        prod_wr;
   logic [NPROD*REG_AW-1:0] prod_dst;

   assign srcs     = {id_src_b, id_src_a};
   assign src_used = {id_src_b_used, id_src_a_used};
   // older producers: index 0 = execute, 1 = memory access
   assign prod_wr  = {mem_wr_en, ex_wr_en};
   assign prod_dst = {mem_wr_dst, ex_wr_dst};

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      hzd_src_match #(.REG_AW(REG_AW), .NPROD(NPROD)) u_match (
         .src      (srcs[s*REG_AW +: REG_AW]),
         .src_used (src_used[s]),
         .prod_wr  (prod_wr),
         .prod_dst (prod_dst),
         .hit      (src_hit[s])
      );
   end

   stage_ctl_t ifid_c, idex_c, exmem_c, memwb_c;
   logic       stall_evt, flush_evt;

   hzd_seq u_seq (
      .rst_n     (rst_n),
      .raw       (|src_hit),
      .port_busy (mem_is_access),
      .taken     (ex_taken),
      .pc_we     (pc_we),
      .ifid      (ifid_c),
      .idex      (idex_c),
      .exmem     (exmem_c),
      .memwb     (memwb_c),
      .stall_evt (stall_evt),
      .flush_evt (flush_evt)
   );

   assign ifid_we   = ifid_c.we;
   assign ifid_clr  = ifid_c.clr;
   assign idex_we   = idex_c.we;
   assign idex_clr  = idex_c.clr;
   assign exmem_we  = exmem_c.we;
   assign exmem_clr = exmem_c.clr;
   assign memwb_we  = memwb_c.we;
   assign memwb_clr = memwb_c.clr;

   // the memory-stage access always wins the shared port
   assign port_to_data = mem_is_access;

   hzd_evt_cnt #(.W(CNT_W)) u_stall_cnt (
      .clk(clk), .rst_n(rst_n), .inc(stall_evt), .count(stall_cnt)
   );
   hzd_evt_cnt #(.W(CNT_W)) u_flush_cnt (
      .clk(clk), .rst_n(rst_n), .inc(flush_evt), .count(flush_cnt)
   );
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ex_taken,
   input logic             pc_we,
   input logic             ifid_we,
   input logic             ifid_clr,
   input logic             idex_clr,
   input logic             exmem_we,
   input logic             exmem_clr,
   input logic             memwb_we,
   input logic             memwb_clr,
   input logic             port_to_data,
   input logic [CNT_W-1:0] stall_cnt,
   input logic [CNT_W-1:0] flush_cnt
);
   a_r1_reset_bubbles: assert property (@(posedge clk)
      !rst_n |-> (ifid_clr && idex_clr && exmem_clr && memwb_clr && pc_we));

   // R2 / R3: a held IF/ID always comes with a bubble into ID/EX
   a_r2_hold_with_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      !ifid_we |-> (!pc_we && idex_clr && !ex_taken));

   a_r5_port_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (port_to_data && !ex_taken) |-> !pc_we);

   a_r6_taken_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      ex_taken |-> (ifid_clr && idex_clr && pc_we));

   a_r7_older_flow: assert property (@(posedge clk) disable iff (!rst_n)
      exmem_we && memwb_we && !exmem_clr && !memwb_clr);

   a_r8_stall_step: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_we |=> (stall_cnt == CNT_W'($past(stall_cnt) + 1'b1)));

   a_r9_flush_step: assert property (@(posedge clk) disable iff (!rst_n)
      ex_taken |=> (flush_cnt == CNT_W'($past(flush_cnt) + 1'b1)));

   a_r10_hold_not_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (port_to_data && !ifid_we) |-> !ifid_clr);
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ex_taken     (ex_taken),
   .pc_we        (pc_we),
   .ifid_we      (ifid_we),
   .ifid_clr     (ifid_clr),
   .idex_clr     (idex_clr),
   .exmem_we     (exmem_we),
   .exmem_clr    (exmem_clr),
   .memwb_we     (memwb_we),
   .memwb_clr    (memwb_clr),
   .port_to_data (port_to_data),
   .stall_cnt    (stall_cnt),
   .flush_cnt    (flush_cnt)
);

// File: tb/hzd_ctrl_test.sv
module hzd_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  id_src_a = '0, id_src_b = '0, ex_wr_dst = '0, mem_wr_dst = '0;
   logic        id_src_a_used = 1'b0, id_src_b_used = 1'b0;
   logic        ex_wr_en = 1'b0, mem_wr_en = 1'b0, mem_is_access = 1'b0, ex_taken = 1'b0;
   logic        pc_we, ifid_we, ifid_clr, idex_we, idex_clr;
   logic        exmem_we, exmem_clr, memwb_we, memwb_clr, port_to_data;
   logic [15:0] stall_cnt, flush_cnt;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;  // 50 MHz

   hzd_ctrl uut (.*);

   typedef struct {
      logic       pc_we, ifid_we, ifid_clr, idex_clr, port;
      logic [15:0] sc, fc;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   model_sc = 0;
   int   model_fc = 0;

   // driver: set inputs for one cycle and queue the expected controls
   task automatic step(input logic [4:0] a, input logic ua, input logic [4:0] b,
                       input logic ub, input logic exw, input logic [4:0] exd,
                       input logic mw, input logic [4:0] md, input logic acc,
                       input logic tk, input string tag);
      exp_t e;
      logic dep;
      @(negedge clk);
      id_src_a = a; id_src_a_used = ua; id_src_b = b; id_src_b_used = ub;
      ex_wr_en = exw; ex_wr_dst = exd; mem_wr_en = mw; mem_wr_dst = md;
      mem_is_access = acc; ex_taken = tk;
      dep = 1'b0;
      if (ua && a != 0 && ((exw && exd == a) || (mw && md == a))) dep = 1'b1;
      if (ub && b != 0 && ((exw && exd == b) || (mw && md == b))) dep = 1'b1;
      e.tag = tag;
      e.port = acc;
      e.sc = 16'(model_sc);
      e.fc = 16'(model_fc);
      if (tk) begin
         e.pc_we = 1; e.ifid_we = 1; e.ifid_clr = 1; e.idex_clr = 1;
         model_fc++;
      end else if (dep) begin
         e.pc_we = 0; e.ifid_we = 0; e.ifid_clr = 0; e.idex_clr = 1;
         model_sc++;
      end else if (acc) begin
         e.pc_we = 0; e.ifid_we = 1; e.ifid_clr = 1; e.idex_clr = 0;
         model_sc++;
      end else begin
         e.pc_we = 1; e.ifid_we = 1; e.ifid_clr = 0; e.idex_clr = 0;
      end
      exp_q.push_back(e);
   endtask

   // monitor: sample mid-low-phase and compare against the queue head
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (pc_we !== e.pc_we || ifid_we !== e.ifid_we || ifid_clr !== e.ifid_clr ||
                idex_clr !== e.idex_clr || port_to_data !== e.port ||
                stall_cnt !== e.sc || flush_cnt !== e.fc ||
                idex_we !== 1'b1 || exmem_we !== 1'b1 || memwb_we !== 1'b1 ||
                exmem_clr !== 1'b0 || memwb_clr !== 1'b0) begin
               errors++;
               $display("FAIL %s (R7 older flow also): got pc=%b ifwe=%b ifclr=%b idclr=%b port=%b sc=%0d fc=%0d exm=%b%b mwb=%b%b exp pc=%b ifwe=%b ifclr=%b idclr=%b port=%b sc=%0d fc=%0d exm=10 mwb=10",
                        e.tag, pc_we, ifid_we, ifid_clr, idex_clr, port_to_data,
                        stall_cnt, flush_cnt, exmem_we, exmem_clr, memwb_we, memwb_clr,
                        e.pc_we, e.ifid_we, e.ifid_clr, e.idex_clr, e.port, e.sc, e.fc);
            end
         end
      end
   end

   initial begin
      #(200000 * 20);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      #5;
      checks++;
      if (!(ifid_clr && idex_clr && exmem_clr && memwb_clr && pc_we) ||
          stall_cnt !== 0 || flush_cnt !== 0) begin
         errors++;
         $display("FAIL R1 reset: got clr=%b%b%b%b pc=%b sc=%0d fc=%0d expected 1111 1 0 0",
                  ifid_clr, idex_clr, exmem_clr, memwb_clr, pc_we, stall_cnt, flush_cnt);
      end
      @(negedge clk);
      rst_n = 1'b1;

      step(5'd3, 1, 5'd4, 1, 0, 5'd0, 0, 5'd0, 0, 0, "R11 idle no hazard");
      step(5'd7, 1, 5'd4, 1, 1, 5'd7, 0, 5'd0, 0, 0, "R2 src a vs execute");
      step(5'd2, 1, 5'd9, 1, 1, 5'd9, 0, 5'd0, 0, 0, "R2 src b vs execute");
      step(5'd12, 1, 5'd1, 0, 0, 5'd0, 1, 5'd12, 0, 0, "R3 src a vs memory");
      step(5'd0, 1, 5'd0, 1, 1, 5'd0, 1, 5'd0, 0, 0, "R4 dest register 0");
      step(5'd6, 1, 5'd8, 1, 0, 5'd6, 0, 5'd8, 0, 0, "R4 write bit clear");
      step(5'd6, 0, 5'd8, 0, 1, 5'd6, 1, 5'd8, 0, 0, "R4 sources unused");
      step(5'd6, 1, 5'd8, 1, 0, 5'd0, 0, 5'd0, 1, 0, "R5 port busy");
      step(5'd6, 1, 5'd8, 1, 1, 5'd8, 0, 5'd0, 1, 0, "R10 data stall plus port");
      step(5'd6, 1, 5'd8, 1, 0, 5'd0, 0, 5'd0, 0, 1, "R6 taken branch");
      step(5'd6, 1, 5'd8, 1, 1, 5'd6, 1, 5'd8, 0, 1, "R6 taken over data stall");
      step(5'd6, 1, 5'd8, 1, 0, 5'd0, 0, 5'd0, 1, 1, "R6 taken over port");
      step(5'd1, 1, 5'd1, 1, 0, 5'd0, 0, 5'd0, 0, 0, "R8 R9 counter totals");
      step(5'd1, 1, 5'd1, 1, 1, 5'd1, 0, 5'd0, 0, 0, "R8 stall again");
      step(5'd1, 1, 5'd1, 1, 0, 5'd0, 0, 5'd0, 0, 0, "R8 R9 final totals");
      repeat (3) @(negedge clk);
      #6;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule